// File: doc/BRIEF.md
# Host-to-Firmware Mailbox Command Writer

This block carries short commands from host logic to an embedded firmware processor through four mailbox slots used in strict rotation. Every slot has a four-byte main box and a two-byte extension box, both reached through a byte-wide register write port. A requester presents an 8-bit element identifier, a payload length and up to five payload bytes. The block selects the slot whose turn it is and polls that slot's consumed flag until the firmware has emptied it. It then packs the bytes according to the length and writes them out. Completion is reported with a one-cycle done pulse and a success flag.

The firmware marks a slot as occupied once the last main-box byte lands, and clears the flag after it reads the command. When the radio is powered down, commands are discarded without touching the port. The block handles one command at a time. A requester that keeps its request raised while another command is running is told to give up after a bounded wait.

Top module: `hmbox_writer`

## Requirements
- R1: A slot pointer starts at 0 after reset and steps 0→1→2→3→0. It moves only when a command has been written completely, and a done pulse with done_ok=1 appears in the same cycle the moved pointer is visible.
- R2: The slot is free when bit `ptr` of `box_busy` reads 0. Polls are POLL_GAP+1 cycles apart, and at most POLL_MAX polls are made. If the slot never frees, done comes with done_ok=0 in cycle 2+(POLL_MAX-1)*(POLL_GAP+1) after the request is taken, and nothing is written. If the slot is free at once, the first write comes 2 cycles after the request is taken.
- R3: Main-box byte 0 (address MAIN_BASE+4*ptr) carries the element identifier bits 6..0. Its bit 7 is 1 when the extension box is used (length 4 or 5) and 0 otherwise.
- R4: For length 1 to 3, main-box bytes 1..3 carry payload bytes 0..2 in order. Bytes beyond the length are written as 0x00, and the extension box is not written.
- R5: For length 4 or 5, payload bytes 0 and 1 go to extension bytes 0 and 1 (addresses EXT_BASE+2*ptr+0/1). Payload bytes 2..4 go to main-box bytes 1..3, with byte 3 written as 0x00 when the length is 4. Both extension writes come before any main-box write.
- R6: Writes occupy back-to-back cycles in ascending address order within each box. Main-box byte 3 is always the last write, and a single-cycle done with done_ok=1 follows in the next cycle.
- R7: If `radio_off` is high when a request is taken, nothing is written. Done with done_ok=0 and len_err=0 follows in the next cycle. This check takes priority over the length check.
- R8: Only one command is handled at a time. A request held high while the block is not idle is not taken. After BUSY_WAIT_MAX consecutive such cycles, a single-cycle `give_up` pulse is raised.
- R9: A length of 0 or above 5 produces done with done_ok=0 and len_err=1 in the next cycle, with no writes. The pointer does not move.
- R10: During and right after reset, wr_en, done, done_ok, len_err and give_up are 0.
- R11: `req_accept` is high exactly in a cycle where `req_valid` is high and the block is idle; that is the cycle the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| radio_off | input | 1 | Radio powered down; commands are dropped |
| req_valid | input | 1 | Command request |
| req_accept | output | 1 | Request taken this cycle |
| req_id | input | 8 | Element identifier |
| req_len | input | 3 | Payload length, valid 1 to 5 |
| req_data | input | 40 | Payload, byte i at bits 8i+7..8i |
| box_busy | input | NUM_BOX | Per-slot firmware-not-yet-consumed flags |
| wr_en | output | 1 | Register byte write strobe |
| wr_addr | output | ADDR_W | Register byte address |
| wr_data | output | 8 | Register byte data |
| done | output | 1 | Command finished (one cycle) |
| done_ok | output | 1 | Command delivered, valid with done |
| len_err | output | 1 | Length rejected, valid with done |
| give_up | output | 1 | Held request waited too long (one cycle) |

## Verification
Commands of every legal length, from 1 to 5, are sent with junk in the unused payload bytes. This separates the narrow and wide packings and shows that bytes past the length are forced to zero. The run covers five or more commands in a row, which takes the pointer around the ring, and lengths 0 and 6 then show that a rejected command leaves the pointer where it was. A slot held busy for a while and then released separates waiting from writing early. A slot held busy forever, with a second request held in parallel, fixes the exact timeout cycle and the give-up cycle. A radio-off request shows the drop path.

// File: rtl/hmbox_pkg.sv
package hmbox_pkg;
   localparam int BYTE_W     = 8;
   localparam int MAIN_BYTES = 4;
   localparam int EXT_BYTES  = 2;
   localparam int MAX_LEN    = MAIN_BYTES - 1 + EXT_BYTES;
   localparam int LEN_W      = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_POLL,
      ST_GAP,
      ST_EXT0,
      ST_EXT1,
      ST_MAIN0,
      ST_MAIN1,
      ST_MAIN2,
      ST_MAIN3,
      ST_FINISH
   } hmb_state_e;
endpackage

// File: rtl/hmbox_packer.sv
module hmbox_packer
   import hmbox_pkg::*;
(
   input  logic [BYTE_W-1:0]                  elem_id,
   input  logic [LEN_W-1:0]                   plen,
   input  logic [MAX_LEN-1:0][BYTE_W-1:0]     payload,
   output logic [MAIN_BYTES-1:0][BYTE_W-1:0]  main_b,
   output logic [EXT_BYTES-1:0][BYTE_W-1:0]   ext_b,
   output logic                               wide
);
   assign wide      = (int'(plen) > MAIN_BYTES - 1);
   assign main_b[0] = {wide, elem_id[BYTE_W-2:0]};

   for (genvar j = 1; j < MAIN_BYTES; j++) begin : g_main
      localparam int NARROW_SRC = j - 1;
      localparam int WIDE_SRC   = EXT_BYTES + j - 1;
      assign main_b[j] = wide ?
         ((WIDE_SRC   < int'(plen)) ? payload[WIDE_SRC]   : '0) :
         ((NARROW_SRC < int'(plen)) ? payload[NARROW_SRC] : '0);
   end

   for (genvar k = 0; k < EXT_BYTES; k++) begin : g_ext
      assign ext_b[k] = wide ? payload[k] : '0;
   end
endmodule

// File: rtl/hmbox_ring_ptr.sv
module hmbox_ring_ptr #(
   parameter int NUM_BOX = 4,
   parameter int PTR_W   = $clog2(NUM_BOX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BOX - 1);

   initial assert (NUM_BOX >= 2) else $error("NUM_BOX must be at least 2");

   if ((1 << PTR_W) == NUM_BOX) begin : g_pow2
      always_ff @(posedge clk) begin
         if (!rst_n)   ptr <= '0;
         else if (adv) ptr <= ptr + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   ptr <= '0;
         else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end

   p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
endmodule

// File: rtl/hmbox_busy_guard.sv
module hmbox_busy_guard #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   output logic give_up
);
   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] wait_cnt;

   initial assert (LIMIT >= 2) else $error("LIMIT must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= '0;
         give_up  <= 1'b0;
      end else begin
         give_up <= waiting && (wait_cnt == CNT_FIRE);
         if (!waiting)                wait_cnt <= '0;
         else if (wait_cnt != CNT_MAX) wait_cnt <= wait_cnt + 1'b1;
      end
   end

   p_give_up_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      give_up |=> !give_up);
endmodule

// File: rtl/hmbox_writer.sv
module hmbox_writer
   import hmbox_pkg::*;
#(
   parameter int NUM_BOX       = 4,
   parameter int POLL_MAX      = 100,
   parameter int POLL_GAP      = 10,
   parameter int BUSY_WAIT_MAX = 1000,
   parameter int ADDR_W        = 12,
   parameter int MAIN_BASE     = 'h1C0,
   parameter int EXT_BASE      = 'h1E0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      radio_off,
   input  logic                      req_valid,
   output logic                      req_accept,
   input  logic [7:0]                req_id,
   input  logic [2:0]                req_len,
   input  logic [8*MAX_LEN-1:0]      req_data,
   input  logic [NUM_BOX-1:0]        box_busy,
   output logic                      wr_en,
   output logic [ADDR_W-1:0]         wr_addr,
   output logic [7:0]                wr_data,
   output logic                      done,
   output logic                      done_ok,
   output logic                      len_err,
   output logic                      give_up
);
   localparam int PTR_W = $clog2(NUM_BOX);
   localparam int PC_W  = $clog2(POLL_MAX + 1);
   localparam int GC_W  = $clog2(POLL_GAP + 1);
   localparam logic [PC_W-1:0] POLL_LAST = PC_W'(POLL_MAX - 1);
   localparam logic [GC_W-1:0] GAP_LAST  = GC_W'(POLL_GAP - 1);

   initial begin
      assert (POLL_MAX >= 1) else $error("POLL_MAX must be at least 1");
      assert (POLL_GAP >= 1) else $error("POLL_GAP must be at least 1");
      assert (ADDR_W >= 8)   else $error("ADDR_W too small");
   end

   hmb_state_e                         state;
   logic [PC_W-1:0]                    poll_cnt;
   logic [GC_W-1:0]                    gap_cnt;
   logic [BYTE_W-1:0]                  id_q;
   logic [LEN_W-1:0]                   len_q;
   logic [MAX_LEN-1:0][BYTE_W-1:0]     data_q;
   logic                               ok_q;
   logic                               lerr_q;
   logic [PTR_W-1:0]                   ptr;
   logic [MAIN_BYTES-1:0][BYTE_W-1:0]  main_b;
   logic [EXT_BYTES-1:0][BYTE_W-1:0]   ext_b;
   logic                               wide;
   logic                               len_bad;
   logic [ADDR_W-1:0]                  main_at;
   logic [ADDR_W-1:0]                  ext_at;

   hmbox_packer u_pack (
      .elem_id (id_q),
      .plen    (len_q),
      .payload (data_q),
      .main_b  (main_b),
      .ext_b   (ext_b),
      .wide    (wide)
   );

   hmbox_ring_ptr #(.NUM_BOX(NUM_BOX)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (state == ST_MAIN3),
      .ptr   (ptr)
   );

   hmbox_busy_guard #(.LIMIT(BUSY_WAIT_MAX)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (req_valid && (state != ST_IDLE)),
      .give_up (give_up)
   );

   assign req_accept = req_valid && (state == ST_IDLE);
   assign len_bad    = (req_len == '0) || (int'(req_len) > MAX_LEN);
   assign done       = (state == ST_FINISH);
   assign done_ok    = done && ok_q;
   assign len_err    = done && lerr_q;
   assign main_at    = ADDR_W'(MAIN_BASE) + ADDR_W'(ptr) * ADDR_W'(MAIN_BYTES);
   assign ext_at     = ADDR_W'(EXT_BASE) + ADDR_W'(ptr) * ADDR_W'(EXT_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         poll_cnt <= '0;
         gap_cnt  <= '0;
         id_q     <= '0;
         len_q    <= '0;
         data_q   <= '0;
         ok_q     <= 1'b0;
         lerr_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               ok_q   <= 1'b0;
               lerr_q <= 1'b0;
               if (radio_off) begin
                  state <= ST_FINISH;
               end else if (len_bad) begin
                  lerr_q <= 1'b1;
                  state  <= ST_FINISH;
               end else begin
                  id_q     <= req_id;
                  len_q    <= req_len;
                  data_q   <= req_data;
                  poll_cnt <= '0;
                  state    <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (!box_busy[ptr])            state <= wide ? ST_EXT0 : ST_MAIN0;
               else if (poll_cnt == POLL_LAST) state <= ST_FINISH;
               else begin
                  poll_cnt <= poll_cnt + 1'b1;
                  gap_cnt  <= '0;
                  state    <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_cnt == GAP_LAST) state <= ST_POLL;
               else                     gap_cnt <= gap_cnt + 1'b1;
            end
            ST_EXT0:  state <= ST_EXT1;
            ST_EXT1:  state <= ST_MAIN0;
            ST_MAIN0: state <= ST_MAIN1;
            ST_MAIN1: state <= ST_MAIN2;
            ST_MAIN2: state <= ST_MAIN3;
            ST_MAIN3: begin
               ok_q  <= 1'b1;
               state <= ST_FINISH;
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_en   = 1'b1;
      wr_addr = '0;
      wr_data = '0;
      unique case (state)
         ST_EXT0:  begin wr_addr = ext_at;          wr_data = ext_b[0];  end
         ST_EXT1:  begin wr_addr = ext_at + 1'b1;   wr_data = ext_b[1];  end
         ST_MAIN0: begin wr_addr = main_at;         wr_data = main_b[0]; end
         ST_MAIN1: begin wr_addr = main_at + 1'b1;  wr_data = main_b[1]; end
         ST_MAIN2: begin wr_addr = main_at + 2'd2;  wr_data = main_b[2]; end
         ST_MAIN3: begin wr_addr = main_at + 2'd3;  wr_data = main_b[3]; end
         default:  wr_en = 1'b0;
      endcase
   end

   p_ptr_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr) |-> (done && done_ok));
   p_wait_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POLL && box_busy[ptr]) |=> !wr_en);
   p_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MAIN0) |-> (wr_data[7] == (int'(len_q) > 3)));
   p_ext_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MAIN0 && wide) |-> ($past(state) == ST_EXT1));
   p_last_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == main_at + 2'd3) |=> (done && done_ok));
   p_radio_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_accept && radio_off) |=> (done && !done_ok && !len_err));
   p_len_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (done && !done_ok));
   p_one_cycle_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/hmbox_writer_tb_top.sv
`timescale 1ns/100ps
module hmbox_writer_tb_top;
   localparam int NUM_BOX   = 4;
   localparam int POLL_MAX  = 100;
   localparam int POLL_GAP  = 10;
   localparam int BUSY_MAX  = 1000;
   localparam int ADDR_W    = 12;
   localparam int MAIN_BASE = 'h1C0;
   localparam int EXT_BASE  = 'h1E0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic radio_off = 1'b0;
   logic req_valid = 1'b0;
   logic req_accept;
   logic [7:0]  req_id = '0;
   logic [2:0]  req_len = '0;
   logic [39:0] req_data = '0;
   logic [NUM_BOX-1:0] box_busy;
   logic wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0] wr_data;
   logic done, done_ok, len_err, give_up;

   always #2.5 clk = ~clk;

   hmbox_writer #(
      .NUM_BOX(NUM_BOX), .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP),
      .BUSY_WAIT_MAX(BUSY_MAX), .ADDR_W(ADDR_W),
      .MAIN_BASE(MAIN_BASE), .EXT_BASE(EXT_BASE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .radio_off(radio_off), .req_valid(req_valid),
      .req_accept(req_accept), .req_id(req_id), .req_len(req_len),
      .req_data(req_data), .box_busy(box_busy), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .done_ok(done_ok),
      .len_err(len_err), .give_up(give_up)
   );

   // firmware model: slot busy after its last main byte, cleared after fw_delay
   logic [NUM_BOX-1:0] fw_busy = '0;
   logic [NUM_BOX-1:0] fw_stuck = '0;
   int fw_cnt [NUM_BOX];
   int fw_delay = 5;
   assign box_busy = fw_busy | fw_stuck;

   always @(posedge clk) begin
      for (int b = 0; b < NUM_BOX; b++) begin
         if (wr_en && int'(wr_addr) == MAIN_BASE + 4*b + 3) begin
            fw_busy[b] <= 1'b1;
            fw_cnt[b]  <= fw_delay;
         end else if (fw_cnt[b] > 1) begin
            fw_cnt[b] <= fw_cnt[b] - 1;
         end else begin
            fw_cnt[b]  <= 0;
            fw_busy[b] <= 1'b0;
         end
      end
   end

   int n_checks = 0;
   int n_fail = 0;
   int exp_ptr = 0;
   int first_seen = 0;
   int qa[$];
   int qd[$];

   task automatic chk(input bit cond, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic build_exp(input logic [7:0] id, input int len, input logic [39:0] d);
      int mb = MAIN_BASE + 4*exp_ptr;
      int eb = EXT_BASE + 2*exp_ptr;
      qa.delete(); qd.delete();
      if (len >= 4) begin
         qa.push_back(eb);     qd.push_back(int'(d[7:0]));
         qa.push_back(eb + 1); qd.push_back(int'(d[15:8]));
         qa.push_back(mb);     qd.push_back(int'({1'b1, id[6:0]}));
         qa.push_back(mb + 1); qd.push_back(int'(d[23:16]));
         qa.push_back(mb + 2); qd.push_back(int'(d[31:24]));
         qa.push_back(mb + 3); qd.push_back((len == 5) ? int'(d[39:32]) : 0);
      end else begin
         qa.push_back(mb); qd.push_back(int'({1'b0, id[6:0]}));
         for (int j = 1; j < 4; j++) begin
            qa.push_back(mb + j);
            qd.push_back((j <= len) ? int'(d[8*(j-1) +: 8]) : 0);
         end
      end
   endtask

   // kind: 0 delivered, 1 length reject, 2 radio drop
   task automatic run_cmd(input logic [7:0] id, input int len, input logic [39:0] d,
                          input int kind, input int min_first, input string tag);
      int c = 1;
      int last_wr = 0;
      bit started = 0;
      bit fin = 0;
      qa.delete(); qd.delete();
      if (kind == 0) build_exp(id, len, d);
      @(negedge clk);
      req_valid = 1'b1; req_id = id; req_len = 3'(len); req_data = d;
      radio_off = (kind == 2);
      #1;
      chk(req_accept == 1'b1, "R11", "accept when idle", req_accept, 1);
      @(negedge clk);
      req_valid = 1'b0; radio_off = 1'b0;
      while (!fin && c < 5000) begin
         if (wr_en) begin
            if (qa.size() == 0) begin
               chk(0, tag, "unexpected write", wr_addr, 0);
            end else begin
               chk(int'(wr_addr) == qa[0], tag, "write address", wr_addr, qa[0]);
               chk(int'(wr_data) == qd[0], tag, "write data", wr_data, qd[0]);
               void'(qa.pop_front()); void'(qd.pop_front());
            end
            if (!started) first_seen = c;
            started = 1; last_wr = c;
         end else if (started && qa.size() != 0) begin
            chk(0, "R6", "gap between writes", 0, 1);
         end
         if (done) begin
            fin = 1;
            chk(qa.size() == 0, "R6", "writes left at done", qa.size(), 0);
            chk(done_ok == (kind == 0), tag, "done_ok", done_ok, kind == 0);
            chk(len_err == (kind == 1), "R9", "len_err", len_err, kind == 1);
            if (kind == 0) chk(c == last_wr + 1, "R6", "done after last write", c, last_wr + 1);
            else begin
               chk(!started, tag, "no write on drop", started, 0);
               chk(c == 1, tag, "drop latency", c, 1);
            end
         end
         if (!fin) begin @(negedge clk); c++; end
      end
      if (!fin) chk(0, tag, "no done", c, 0);
      if (kind == 0) begin
         if (min_first == 2) chk(first_seen == 2, "R2", "first write on free slot", first_seen, 2);
         else chk(first_seen >= min_first, "R2", "write before slot freed", first_seen, min_first);
         exp_ptr = (exp_ptr + 1) % NUM_BOX;
      end
      @(negedge clk);
      chk(!done, "R6", "done one cycle", done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      int gu_c, dn_c, c;
      bit wrote;
      repeat (3) @(negedge clk);
      chk(!wr_en && !done && !give_up && !done_ok && !len_err, "R10", "outputs in reset",
          {wr_en, done, give_up}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!wr_en && !done && !give_up && !req_accept, "R10", "outputs after reset",
          {wr_en, done, give_up}, 0);

      // narrow lengths with junk beyond the length, slots 0,1,2
      run_cmd(8'hA5, 1, 40'hFF_EE_DD_CC_11, 0, 2, "R4");
      run_cmd(8'h3C, 2, 40'h99_88_77_22_33, 0, 2, "R4");
      run_cmd(8'h81, 3, 40'h55_66_44_55_66, 0, 2, "R3");
      // wide lengths, slots 3 then wrap to 0
      run_cmd(8'h12, 4, 40'hAB_04_03_02_01, 0, 2, "R5");
      run_cmd(8'hF0, 5, 40'h15_14_13_12_11, 0, 2, "R1");
      // bad lengths, pointer stays at 1
      run_cmd(8'h07, 0, 40'h0, 1, 2, "R9");
      run_cmd(8'h07, 6, 40'h0, 1, 2, "R9");
      run_cmd(8'h44, 2, 40'h00_00_00_BE_EF, 0, 2, "R9");
      // radio off, bad length too: radio wins
      run_cmd(8'h50, 3, 40'h1, 2, 2, "R7");
      run_cmd(8'h51, 7, 40'h1, 2, 2, "R7");
      run_cmd(8'h52, 1, 40'h7E, 0, 2, "R1");

      // slot held busy then released: slot 3
      fw_stuck[exp_ptr] = 1'b1;
      fork
         run_cmd(8'h63, 3, 40'h00_00_30_20_10, 0, 30, "R2");
         begin repeat (30) @(negedge clk); fw_stuck = '0; end
      join

      // slot 0 stuck forever, second request held meanwhile
      fw_stuck[exp_ptr] = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_id = 8'h70; req_len = 3'd2; req_data = 40'h1234;
      @(negedge clk);
      req_id = 8'h71;
      gu_c = 0; dn_c = 0; wrote = 0; c = 1;
      while (dn_c == 0 && c < 5000) begin
         if (wr_en) wrote = 1;
         if (give_up) begin
            if (gu_c == 0) gu_c = c;
            req_valid = 1'b0;
         end
         if (done) begin
            dn_c = c;
            chk(!done_ok, "R2", "timeout done_ok", done_ok, 0);
         end
         if (dn_c == 0) begin @(negedge clk); c++; end
      end
      chk(!wrote, "R2", "no write on timeout", wrote, 0);
      chk(dn_c == 2 + (POLL_MAX - 1) * (POLL_GAP + 1), "R2", "timeout cycle",
          dn_c, 2 + (POLL_MAX - 1) * (POLL_GAP + 1));
      chk(gu_c == BUSY_MAX + 1, "R8", "give_up cycle", gu_c, BUSY_MAX + 1);
      req_valid = 1'b0;
      @(negedge clk);
      chk(!req_accept && !give_up, "R8", "second request not taken", req_accept, 0);
      fw_stuck = '0;
      // pointer unchanged after timeout: goes to slot 0
      run_cmd(8'h33, 5, 40'h05_04_03_02_01, 0, 2, "R1");

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule